// File: doc/BRIEF.md
# Variable-Block-Size SAD Merge and Minimum Tracker

This block sits behind a full-search motion estimation array for one 16x16 macroblock. For every candidate displacement the array delivers sixteen 4x4 sub-block sums of absolute differences. The block adds these up through a single adder tree into the costs of all 41 partitions of the macroblock, covering seven shapes: one 16x16, two 16x8, two 8x16, four 8x8, eight 8x4, eight 4x8 and sixteen 4x4.

Each of the 41 partitions has its own comparator and storage. These keep the lowest cost seen so far and the candidate vector that produced it. A start pulse opens a new macroblock. A done flag rises once the whole window has been scanned. The window holds N_CAND accepted candidates, 64 by 64 = 4096 by default for offsets from -32 to +31. The vectors are 7-bit two's-complement components. They are passed through as given, and in raster order the vertical offset is the outer loop.

Top module: `vbs_sad_merge_min`

## Requirements
- R1: While rst_n is low, and after it is released, every stored SAD is all-ones (0xFFFF), every stored vector component is 0 and search_done is 0.
- R2: Input 4x4 SAD i sits at sad4_flat[i*12 +: 12], where i = row*4 + col in raster order. The partitions are numbered as follows. Index 0 is 16x16. Indices 1-2 are 16x8, top then bottom. Indices 3-4 are 8x16, left then right. Indices 5-8 are 8x8 in raster order. Indices 9+2b+k are 8x4 in 8x8 quadrant b, where k=0 is the upper half. Indices 17+2b+k are 4x8 in quadrant b, where k=0 is the left half. Indices 25+i are 4x4 cell i. A partition's cost is the sum of the 4x4 SADs it covers.
- R3: When a candidate is accepted, every partition whose cost is strictly lower than its stored SAD takes that cost and the candidate's vector. The result appears in the cycle after the candidate is presented.
- R4: When a partition's cost equals its stored SAD, the stored SAD and vector are kept, so the earlier candidate wins.
- R5: A cycle with cand_valid low changes no stored SAD, vector or count.
- R6: A cycle with mb_start high restores the state of R1. A candidate presented in that same cycle is discarded.
- R7: search_done rises in the cycle after the N_CAND-th accepted candidate is presented. It stays high until mb_start or reset.
- R8: Candidates presented while search_done is high are ignored.
- R9: The stored SADs are 16 bits wide. Sixteen 4x4 SADs of 4095 give a 16x16 cost of 65520, which is stored without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mb_start | input | 1 | Start of a new macroblock search |
| cand_valid | input | 1 | Candidate SADs and vector are valid |
| cand_mvx | input | 7 | Candidate horizontal offset, two's complement |
| cand_mvy | input | 7 | Candidate vertical offset, two's complement |
| sad4_flat | input | 192 | Sixteen 12-bit 4x4 SADs, raster order |
| best_sad_flat | output | 656 | 41 stored minimum SADs, 16 bits each, partition p at [p*16 +: 16] |
| best_mvx_flat | output | 287 | 41 stored horizontal offsets, 7 bits each |
| best_mvy_flat | output | 287 | 41 stored vertical offsets, 7 bits each |
| search_done | output | 1 | Window fully scanned |

## Verification
Every stored minimum is a port, so a wrong partition sum or a wrong comparison shows up in the cycle after the offending candidate. It appears either in that partition's SAD or in its vector, and a tie taken the wrong way changes only the vector. A miscounted candidate counter is hidden until the end of the window, where search_done rises one cycle early or late. A missing done gate shows up on the first candidate after the flag rises. The reference model therefore compares all 41 entries and the flag on every clock, across random, low-range, constant and saturated SAD patterns.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
   // 4x4 grid of the macroblock
   localparam int GRID  = 4;
   localparam int NCELL = GRID * GRID;
   // partition count and base index of each shape
   localparam int NPART  = 41;
   localparam int B16    = 0;
   localparam int B16X8  = 1;
   localparam int B8X16  = 3;
   localparam int B8     = 5;
   localparam int B8X4   = 9;
   localparam int B4X8   = 17;
   localparam int B4     = 25;
   // a 16x16 sum holds 16 4x4 sums: four extra bits
   localparam int GROW_W = 4;
endpackage

// File: rtl/vbs_adder_tree.sv
module vbs_adder_tree
   import vbs_pkg::*;
#(
   parameter int SAD4_W = 12,
   parameter int SAD_W  = SAD4_W + GROW_W
) (
   input  logic [NCELL*SAD4_W-1:0] sad4_flat,
   output logic [SAD_W-1:0]        psad [NPART]
);
   logic [SAD_W-1:0] g   [GRID][GRID];
   logic [SAD_W-1:0] s8  [4];
   logic [SAD_W-1:0] s16x8 [2];

   for (genvar i = 0; i < NCELL; i++) begin : g_cell
      localparam int R = i / GRID;
      localparam int C = i % GRID;
      assign g[R][C]      = {{(SAD_W-SAD4_W){1'b0}}, sad4_flat[i*SAD4_W +: SAD4_W]};
      assign psad[B4 + i] = g[R][C];
   end

   for (genvar b = 0; b < 4; b++) begin : g_quad
      localparam int R0 = (b / 2) * 2;
      localparam int C0 = (b % 2) * 2;
      logic [SAD_W-1:0] up, lo, lf, rt;
      assign up = g[R0][C0]   + g[R0][C0+1];
      assign lo = g[R0+1][C0] + g[R0+1][C0+1];
      assign lf = g[R0][C0]   + g[R0+1][C0];
      assign rt = g[R0][C0+1] + g[R0+1][C0+1];
      assign psad[B8X4 + 2*b]     = up;
      assign psad[B8X4 + 2*b + 1] = lo;
      assign psad[B4X8 + 2*b]     = lf;
      assign psad[B4X8 + 2*b + 1] = rt;
      assign s8[b]                = up + lo;
      assign psad[B8 + b]         = s8[b];
   end

   assign s16x8[0]     = s8[0] + s8[1];
   assign s16x8[1]     = s8[2] + s8[3];
   assign psad[B16X8]     = s16x8[0];
   assign psad[B16X8 + 1] = s16x8[1];
   assign psad[B8X16]     = s8[0] + s8[2];
   assign psad[B8X16 + 1] = s8[1] + s8[3];
   assign psad[B16]       = s16x8[0] + s16x8[1];
endmodule

// File: rtl/vbs_min_cell.sv
module vbs_min_cell #(
   parameter int SAD_W = 16,
   parameter int MV_W  = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             upd_en,
   input  logic [SAD_W-1:0] cand_sad,
   input  logic [MV_W-1:0]  cand_mvx,
   input  logic [MV_W-1:0]  cand_mvy,
   output logic [SAD_W-1:0] best_sad,
   output logic [MV_W-1:0]  best_mvx,
   output logic [MV_W-1:0]  best_mvy
);
   logic better;
   assign better = upd_en && (cand_sad < best_sad);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_sad <= '1;
         best_mvx <= '0;
         best_mvy <= '0;
      end else if (clr) begin
         best_sad <= '1;
         best_mvx <= '0;
         best_mvy <= '0;
      end else if (better) begin
         best_sad <= cand_sad;
         best_mvx <= cand_mvx;
         best_mvy <= cand_mvy;
      end
   end

   // R3
   no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> best_sad <= $past(best_sad));
   // R4
   tie_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && upd_en && cand_sad == best_sad) |=>
         ($stable(best_sad) && $stable(best_mvx) && $stable(best_mvy)));
   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !upd_en) |=> ($stable(best_sad) && $stable(best_mvx)));
   // R6
   clr_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (&best_sad && best_mvx == '0 && best_mvy == '0));
endmodule

// File: rtl/vbs_scan_ctrl.sv
module vbs_scan_ctrl #(
   parameter int N_CAND = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mb_start,
   input  logic cand_valid,
   output logic clr,
   output logic upd_en,
   output logic done
);
   localparam int CNT_W = $clog2(N_CAND + 1);
   logic [CNT_W-1:0] cnt;

   assign clr    = mb_start;
   assign upd_en = cand_valid && !mb_start && !done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (mb_start) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (upd_en) begin
         cnt <= cnt + 1'b1;
         if (cnt == CNT_W'(N_CAND - 1)) done <= 1'b1;
      end
   end

   // R7
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !mb_start) |=> done);
   // R7
   done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cnt == CNT_W'(N_CAND));
   // R8
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(N_CAND));
   // R5
   idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cand_valid && !mb_start) |=> $stable(cnt));
endmodule

// File: rtl/vbs_sad_merge_min.sv
module vbs_sad_merge_min
   import vbs_pkg::*;
#(
   parameter int SAD4_W = 12,
   parameter int MV_W   = 7,
   parameter int N_CAND = 4096
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              mb_start,
   input  logic                              cand_valid,
   input  logic [MV_W-1:0]                   cand_mvx,
   input  logic [MV_W-1:0]                   cand_mvy,
   input  logic [NCELL*SAD4_W-1:0]           sad4_flat,
   output logic [NPART*(SAD4_W+GROW_W)-1:0]  best_sad_flat,
   output logic [NPART*MV_W-1:0]             best_mvx_flat,
   output logic [NPART*MV_W-1:0]             best_mvy_flat,
   output logic                              search_done
);
   localparam int SAD_W = SAD4_W + GROW_W;

   if (SAD4_W < 1) begin : g_bad_sad
      $error("SAD4_W must be positive");
   end
   if (MV_W < 2) begin : g_bad_mv
      $error("MV_W must be at least 2");
   end
   if (N_CAND < 1) begin : g_bad_cand
      $error("N_CAND must be positive");
   end

   logic [SAD_W-1:0] psad [NPART];
   logic clr, upd_en;

   vbs_adder_tree #(.SAD4_W(SAD4_W), .SAD_W(SAD_W)) u_tree (
      .sad4_flat (sad4_flat),
      .psad      (psad)
   );

   vbs_scan_ctrl #(.N_CAND(N_CAND)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .mb_start   (mb_start),
      .cand_valid (cand_valid),
      .clr        (clr),
      .upd_en     (upd_en),
      .done       (search_done)
   );

   for (genvar p = 0; p < NPART; p++) begin : g_part
      vbs_min_cell #(.SAD_W(SAD_W), .MV_W(MV_W)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (clr),
         .upd_en   (upd_en),
         .cand_sad (psad[p]),
         .cand_mvx (cand_mvx),
         .cand_mvy (cand_mvy),
         .best_sad (best_sad_flat[p*SAD_W +: SAD_W]),
         .best_mvx (best_mvx_flat[p*MV_W +: MV_W]),
         .best_mvy (best_mvy_flat[p*MV_W +: MV_W])
      );
   end

   // R2
   tree_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psad[B16] == psad[B8X16] + psad[B8X16+1]);
   // R2
   tree_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psad[B8] == psad[B4X8] + psad[B4X8+1]);
   // R8
   done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (search_done && !mb_start) |=> $stable(best_sad_flat));
endmodule

// File: tb/test_vbs_sad_merge_min.sv
module test_vbs_sad_merge_min;
   localparam int NP = 41;
   localparam int NC = 4096;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mb_start = 1'b0;
   logic cand_valid = 1'b0;
   logic [6:0] cand_mvx = '0;
   logic [6:0] cand_mvy = '0;
   logic [16*12-1:0] sad4_flat = '0;
   logic [NP*16-1:0] best_sad_flat;
   logic [NP*7-1:0]  best_mvx_flat;
   logic [NP*7-1:0]  best_mvy_flat;
   logic search_done;

   always #5 clk = ~clk;

   vbs_sad_merge_min i_vbs_sad_merge_min (
      .clk(clk), .rst_n(rst_n), .mb_start(mb_start), .cand_valid(cand_valid),
      .cand_mvx(cand_mvx), .cand_mvy(cand_mvy), .sad4_flat(sad4_flat),
      .best_sad_flat(best_sad_flat), .best_mvx_flat(best_mvx_flat),
      .best_mvy_flat(best_mvy_flat), .search_done(search_done)
   );

   int total = 0;
   int bad   = 0;
   int cur [16];
   int m_sad [NP];
   logic [6:0] m_mvx [NP];
   logic [6:0] m_mvy [NP];
   int m_cnt = 0;
   bit m_done = 0;

   task automatic note(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // partition rectangle in 4x4 units
   function automatic int part_cost(int p);
      int x, y, w, h, q, b, k, s;
      if (p == 0) begin x = 0; y = 0; w = 4; h = 4; end
      else if (p < 3) begin x = 0; y = (p-1)*2; w = 4; h = 2; end
      else if (p < 5) begin x = (p-3)*2; y = 0; w = 2; h = 4; end
      else if (p < 9) begin b = p-5; x = (b%2)*2; y = (b/2)*2; w = 2; h = 2; end
      else if (p < 17) begin
         q = p-9; b = q/2; k = q%2; x = (b%2)*2; y = (b/2)*2 + k; w = 2; h = 1;
      end else if (p < 25) begin
         q = p-17; b = q/2; k = q%2; x = (b%2)*2 + k; y = (b/2)*2; w = 1; h = 2;
      end else begin q = p-25; x = q%4; y = q/4; w = 1; h = 1; end
      s = 0;
      for (int yy = y; yy < y+h; yy++)
         for (int xx = x; xx < x+w; xx++) s += cur[yy*4+xx];
      return s;
   endfunction

   task automatic model_clear();
      for (int p = 0; p < NP; p++) begin
         m_sad[p] = 65535; m_mvx[p] = '0; m_mvy[p] = '0;
      end
      m_cnt = 0; m_done = 0;
   endtask

   task automatic compare_all(string tag);
      int nsad = 0, nmv = 0, fsad = -1, fmv = -1;
      for (int p = 0; p < NP; p++) begin
         if (int'(best_sad_flat[p*16 +: 16]) != m_sad[p]) begin
            nsad++; if (fsad < 0) fsad = p;
         end
         if (best_mvx_flat[p*7 +: 7] != m_mvx[p] || best_mvy_flat[p*7 +: 7] != m_mvy[p]) begin
            nmv++; if (fmv < 0) fmv = p;
         end
      end
      if (fsad >= 0)
         note(0, {tag, " R2/R3 sad of partition"}, int'(best_sad_flat[fsad*16 +: 16]), m_sad[fsad]);
      else note(1, "", 0, 0);
      if (fmv >= 0)
         note(0, {tag, " R3/R4 vector of partition"}, int'(best_mvx_flat[fmv*7 +: 7]), int'(m_mvx[fmv]));
      else note(1, "", 0, 0);
      note(search_done == m_done, {tag, " R7 done"}, int'(search_done), int'(m_done));
   endtask

   task automatic step(bit v, bit s, int mx, int my, string tag);
      cand_valid = v; mb_start = s;
      cand_mvx = mx[6:0]; cand_mvy = my[6:0];
      for (int i = 0; i < 16; i++) sad4_flat[i*12 +: 12] = cur[i][11:0];
      if (s) model_clear();
      else if (v && !m_done) begin
         for (int p = 0; p < NP; p++) begin
            int c = part_cost(p);
            if (c < m_sad[p]) begin
               m_sad[p] = c; m_mvx[p] = mx[6:0]; m_mvy[p] = my[6:0];
            end
         end
         m_cnt++;
         if (m_cnt == NC) m_done = 1;
      end
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
   endtask

   task automatic fill(int mode);
      for (int i = 0; i < 16; i++) begin
         case (mode)
            0: cur[i] = int'($urandom_range(4095, 0));
            1: cur[i] = int'($urandom_range(7, 0));
            2: cur[i] = 4095;
            default: cur[i] = 100;
         endcase
      end
   endtask

   task automatic run_window(int first_mode, int zero_at);
      int k = 0;
      for (int vy = -32; vy < 32; vy++) begin
         for (int vx = -32; vx < 32; vx++) begin
            if (k % 37 == 36) begin
               // R5: idle cycle with garbage that would win
               for (int i = 0; i < 16; i++) cur[i] = 0;
               step(0, 0, 5, 5, "R5 idle");
            end
            if (k == zero_at) for (int i = 0; i < 16; i++) cur[i] = 0;
            else if (k == 0) fill(first_mode);
            else fill((k / 300) % 4);
            step(1, 0, vx, vy, "R3 scan");
            k++;
         end
      end
   endtask

   initial begin
      for (int i = 0; i < 16; i++) cur[i] = 0;
      model_clear();
      repeat (3) @(negedge clk);
      // R1: reset state
      note(&best_sad_flat, "R1 reset sad all ones", int'(best_sad_flat[15:0]), 65535);
      note(best_mvx_flat == '0 && best_mvy_flat == '0, "R1 reset vectors", int'(best_mvx_flat[6:0]), 0);
      note(search_done == 1'b0, "R1 reset done", int'(search_done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1 after release");
      step(0, 1, 0, 0, "R6 start");
      run_window(0, 4000);
      note(search_done == 1'b1, "R7 done after window", int'(search_done), 1);
      // R8: winning candidate after done is ignored
      for (int i = 0; i < 16; i++) cur[i] = 0;
      step(1, 0, 3, 3, "R8 after done");
      note(int'(best_mvx_flat[0 +: 7]) != 3, "R8 vector untouched", int'(best_mvx_flat[0 +: 7]), 0);
      // R6: start with a candidate in the same cycle
      step(1, 1, 9, 9, "R6 start+valid");
      note(&best_sad_flat, "R6 minima cleared", int'(best_sad_flat[15:0]), 65535);
      // R9: saturated first candidate
      fill(2);
      step(1, 0, -32, -32, "R9 max");
      note(int'(best_sad_flat[15:0]) == 65520, "R9 16x16 max sum", int'(best_sad_flat[15:0]), 65520);
      note(int'(best_sad_flat[25*16 +: 16]) == 4095, "R2 4x4 cell 0", int'(best_sad_flat[25*16 +: 16]), 4095);
      // R4: equal cost keeps the earlier vector
      step(1, 0, 1, 1, "R4 tie");
      note(best_mvx_flat[6:0] == 7'h60, "R4 tie keeps earlier", int'(best_mvx_flat[6:0]), 96);
      step(0, 1, 0, 0, "R6 second start");
      run_window(3, 2000);
      note(search_done == 1'b1, "R7 done second window", int'(search_done), 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule